// File: doc/BRIEF.md
# Programmable Gate Pulse Generator

This block produces a periodic measurement gate from a free-running reference-clock counter. The design clock is the reference clock. Each period has a high phase of fixed length, equal to 40 ms of reference ticks. It is followed by a low phase that takes up the rest of the requested gate time. A frequency counter elsewhere on the chip can use the gate edges, or the one-cycle `periodStart` pulse, to capture its own count.

The host supplies the reference rate in ticks per second and a gate time in milliseconds, then pulses `loadStrobe`. The block clamps the gate time and computes the new phase lengths with a serial shift-add multiplier and a restoring divide-by-1000. While it works, `busy` is high. The result is held pending. It replaces the active lengths only at the edge where a low phase ends, so the period in progress always finishes with the old lengths. Toggle times are found by adding the active phase length to the previous compare value, modulo 2^32.

Top module: `gate_pulse_gen`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, `gateOut` is 1 and `periodStart` and `busy` are 0. From release, the first high phase lasts INIT_HIGH cycles and the first low phase lasts INIT_LOW cycles (40 and 60 by default).
- R2: With no load pending, the gate keeps repeating the active high length followed by the active low length.
- R3: For rate r (ticks/s) and gate time m (ms), the total length is T = floor((r*m + 500)/1000), so a fraction of 0.5 or more rounds up. The high length is H = floor(r*40/1000) and the low length is T - H.
- R4: Before the computation, m is clamped to the range 50 to 60000. A value below 50 is used as 50, and a value above 60000 is used as 60000.
- R5: A strobe accepted while idle makes `busy` high from the next cycle for exactly 115 cycles (MS_W + 2*(RATE_W+MS_W) + 3). When `busy` falls, the result is pending.
- R6: A `loadStrobe` that arrives while `busy` is high is ignored. It neither restarts nor alters the computation.
- R7: Pending lengths take effect only at a low-to-high gate transition. A phase that is running when the result becomes pending keeps its old length.
- R8: If the computation completes on the same clock edge where a low phase ends, that edge starts a period with the old lengths. The new lengths start at the following low-to-high transition.
- R9: `periodStart` is high for exactly one cycle, the first high cycle after each low-to-high transition. It is not asserted for the initial high phase after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the timer counts its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| refRate | input | 32 | Reference clock rate in ticks per second, sampled on an accepted strobe |
| gateMs | input | 16 | Requested gate time in milliseconds, sampled on an accepted strobe |
| loadStrobe | input | 1 | Starts a new computation when idle |
| gateOut | output | 1 | Gate level |
| periodStart | output | 1 | One-cycle pulse at the start of each high phase |
| busy | output | 1 | High while the phase lengths are being computed |

## Verification
Two functions can act on the same clock edge. One is the end of the computation, which writes the pending lengths. The other is the end of a low phase, which consumes the pending lengths. The bench provokes this by placing a strobe exactly 115 cycles before a known rising edge of the gate. It first confirms that `busy` falls in the same cycle that `periodStart` rises. It then judges the result by the measured phase lengths: the period that starts on that edge must keep the old low length, and the next period must show the new one.

// File: rtl/gate_pulse_pkg.sv
package gate_pulse_pkg;

  localparam int MS_MIN     = 50;
  localparam int MS_MAX     = 60000;
  localparam int MS_PER_SEC = 1000;
  localparam int HIGH_MS    = 40;

  // strobes from the sequencer to the arithmetic datapath
  typedef struct packed {
    logic latch;      // capture rate and clamped gate time
    logic mulStep;    // one shift-add multiplier step
    logic prepTotal;  // load rounded product into divider
    logic divStep;    // one restoring division step
    logic prepHigh;   // save total, load rate*HIGH_MS into divider
    logic writePend;  // write pending high/low lengths
  } calcCtl_t;

endpackage

// File: rtl/gate_pulse_ctrl.sv
module gate_pulse_ctrl
  import gate_pulse_pkg::*;
#(
  parameter int MS_W   = 16,
  parameter int PROD_W = 48
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     loadStrobe,
  output calcCtl_t ctl,
  output logic     busy
);

  localparam int STEP_W = $clog2(PROD_W + 1);
  localparam logic [STEP_W-1:0] MUL_LAST = STEP_W'(MS_W - 1);
  localparam logic [STEP_W-1:0] DIV_LAST = STEP_W'(PROD_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_MUL, S_PREPT, S_DIVT, S_PREPH, S_DIVH, S_WRITE
  } calcState_t;

  calcState_t        state;
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= '0;
    end else begin
      case (state)
        S_IDLE: if (loadStrobe) begin
          state <= S_MUL;
          step  <= '0;
        end
        S_MUL: if (step == MUL_LAST) begin
          state <= S_PREPT;
          step  <= '0;
        end else step <= step + STEP_W'(1);
        S_PREPT: state <= S_DIVT;
        S_DIVT: if (step == DIV_LAST) begin
          state <= S_PREPH;
          step  <= '0;
        end else step <= step + STEP_W'(1);
        S_PREPH: state <= S_DIVH;
        S_DIVH: if (step == DIV_LAST) begin
          state <= S_WRITE;
          step  <= '0;
        end else step <= step + STEP_W'(1);
        S_WRITE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.latch     = (state == S_IDLE) && loadStrobe;
    ctl.mulStep   = (state == S_MUL);
    ctl.prepTotal = (state == S_PREPT);
    ctl.divStep   = (state == S_DIVT) || (state == S_DIVH);
    ctl.prepHigh  = (state == S_PREPH);
    ctl.writePend = (state == S_WRITE);
    busy          = (state != S_IDLE);
  end

  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadStrobe) |=> busy); // R5

endmodule

// File: rtl/gate_pulse_dp.sv
module gate_pulse_dp
  import gate_pulse_pkg::*;
#(
  parameter int RATE_W    = 32,
  parameter int MS_W      = 16,
  parameter int CNT_W     = 32,
  parameter int INIT_HIGH = 40,
  parameter int INIT_LOW  = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] refRate,
  input  logic [MS_W-1:0]   gateMs,
  input  calcCtl_t          ctl,
  input  logic              busy,
  output logic              gateLvl,
  output logic              periodStart,
  output logic              pendReady
);

  localparam int PROD_W = RATE_W + MS_W;
  localparam int REM_W  = $clog2(MS_PER_SEC) + 1;
  localparam logic [REM_W-1:0] DIVISOR = REM_W'(MS_PER_SEC);

  // arithmetic state
  logic [PROD_W-1:0] mcand, acc, quo;
  logic [MS_W-1:0]   mplier, msHold, msClamped;
  logic [RATE_W-1:0] rateHold;
  logic [REM_W-1:0]  rem, remShift, remNext;
  logic              divFits;
  logic [CNT_W-1:0]  totReg, pendHigh, pendLow;

  // timer state
  logic [CNT_W-1:0]  cnt, cmp, actHigh, actLow;
  logic              hit;

  always_comb begin
    if (gateMs < MS_W'(MS_MIN))      msClamped = MS_W'(MS_MIN);
    else if (gateMs > MS_W'(MS_MAX)) msClamped = MS_W'(MS_MAX);
    else                             msClamped = gateMs;
    remShift = {rem[REM_W-2:0], quo[PROD_W-1]};
    divFits  = (remShift >= DIVISOR);
    remNext  = divFits ? (remShift - DIVISOR) : remShift;
    hit      = (cnt == cmp);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand    <= '0;
      mplier   <= '0;
      acc      <= '0;
      quo      <= '0;
      rem      <= '0;
      rateHold <= '0;
      msHold   <= MS_W'(MS_MIN);
      totReg   <= '0;
      pendHigh <= '0;
      pendLow  <= '0;
    end else begin
      if (ctl.latch) begin
        mcand    <= PROD_W'(refRate);
        mplier   <= msClamped;
        acc      <= '0;
        rateHold <= refRate;
        msHold   <= msClamped;
      end
      if (ctl.mulStep) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= {mcand[PROD_W-2:0], 1'b0};
        mplier <= mplier >> 1;
      end
      if (ctl.prepTotal) begin
        quo <= acc + PROD_W'(MS_PER_SEC / 2);
        rem <= '0;
      end
      if (ctl.divStep) begin
        quo <= {quo[PROD_W-2:0], divFits};
        rem <= remNext;
      end
      if (ctl.prepHigh) begin
        totReg <= quo[CNT_W-1:0];
        quo    <= PROD_W'(rateHold) * PROD_W'(HIGH_MS);
        rem    <= '0;
      end
      if (ctl.writePend) begin
        pendHigh <= quo[CNT_W-1:0];
        pendLow  <= totReg - quo[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      cmp         <= CNT_W'(INIT_HIGH - 1);
      actHigh     <= CNT_W'(INIT_HIGH);
      actLow      <= CNT_W'(INIT_LOW);
      gateLvl     <= 1'b1;
      periodStart <= 1'b0;
      pendReady   <= 1'b0;
    end else begin
      cnt         <= cnt + CNT_W'(1);
      periodStart <= 1'b0;
      if (hit) begin
        if (gateLvl) begin
          gateLvl <= 1'b0;
          cmp     <= cmp + actLow;
        end else begin
          gateLvl     <= 1'b1;
          periodStart <= 1'b1;
          if (pendReady) begin
            actHigh <= pendHigh;
            actLow  <= pendLow;
            cmp     <= cmp + pendHigh;
          end else begin
            cmp <= cmp + actHigh;
          end
        end
      end
      if (ctl.writePend)          pendReady <= 1'b1;
      else if (hit && !gateLvl)   pendReady <= 1'b0;
    end
  end

  AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (msHold >= MS_W'(MS_MIN) && msHold <= MS_W'(MS_MAX))); // R4
  AST_APPLY_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(actHigh) || !$stable(actLow)) |-> periodStart); // R7
  AST_PULSE_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |-> (gateLvl && !$past(gateLvl))); // R9
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !periodStart); // R9

endmodule

// File: rtl/gate_pulse_gen.sv
module gate_pulse_gen
  import gate_pulse_pkg::*;
#(
  parameter int RATE_W    = 32,
  parameter int MS_W      = 16,
  parameter int CNT_W     = 32,
  parameter int INIT_HIGH = 40,
  parameter int INIT_LOW  = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] refRate,
  input  logic [MS_W-1:0]   gateMs,
  input  logic              loadStrobe,
  output logic              gateOut,
  output logic              periodStart,
  output logic              busy
);

  localparam int PROD_W = RATE_W + MS_W;

  calcCtl_t ctl;
  logic     pendReady;

  gate_pulse_ctrl #(.MS_W(MS_W), .PROD_W(PROD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .ctl(ctl), .busy(busy)
  );

  gate_pulse_dp #(
    .RATE_W(RATE_W), .MS_W(MS_W), .CNT_W(CNT_W),
    .INIT_HIGH(INIT_HIGH), .INIT_LOW(INIT_LOW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .refRate(refRate), .gateMs(gateMs), .ctl(ctl),
    .busy(busy), .gateLvl(gateOut), .periodStart(periodStart),
    .pendReady(pendReady)
  );

  AST_PEND_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> pendReady); // R5

endmodule

// File: tb/gate_pulse_gen_tb.sv
module gate_pulse_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] refRate = 32'd1000;
  logic [15:0] gateMs = 16'd100;
  logic        loadStrobe = 1'b0;
  logic        gateOut, periodStart, busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gate_pulse_gen u_dut (
    .clk(clk), .rstN(rstN), .refRate(refRate), .gateMs(gateMs),
    .loadStrobe(loadStrobe), .gateOut(gateOut), .periodStart(periodStart),
    .busy(busy)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint clampMs(input longint ms);
    return (ms < 50) ? 50 : ((ms > 60000) ? 60000 : ms);
  endfunction
  function automatic longint expHigh(input longint r);
    return (r * 40) / 1000;
  endfunction
  function automatic longint expLow(input longint r, input longint ms);
    return (r * clampMs(ms) + 500) / 1000 - expHigh(r);
  endfunction

  task automatic measurePeriod(output int h, output int l, output int p);
    h = 0; l = 0; p = 0;
    while (gateOut === 1'b1) begin h++; if (periodStart) p++; @(negedge clk); end
    while (gateOut === 1'b0) begin l++; if (periodStart) p++; @(negedge clk); end
  endtask

  task automatic checkPeriod(input string req, input longint eh, input longint el);
    int h, l, p;
    measurePeriod(h, l, p);
    chk({req, " high length"}, h, eh);
    chk({req, " low length"}, l, el);
    chk("R9 one start pulse per period", p, 1);
  endtask

  task automatic doLoad(input longint r, input longint ms);
    refRate = 32'(r); gateMs = 16'(ms); loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic waitStart();
    do @(negedge clk); while (!periodStart);
  endtask

  task automatic testReset();
    int h, l, p;
    repeat (5) @(negedge clk);
    chk("R1 gate during reset", gateOut, 1);
    chk("R1 pulse during reset", periodStart, 0);
    chk("R1 busy during reset", busy, 0);
    rstN = 1'b1;
    chk("R1 gate after release", gateOut, 1);
    measurePeriod(h, l, p);
    chk("R1 first high", h, 40);
    chk("R1 first low", l, 60);
    chk("R9 no pulse for initial high", p, 0);
    chk("R9 pulse at first rise", periodStart, 1);
    checkPeriod("R2 repeat", 40, 60);
  endtask

  task automatic testDeferred();
    int c, h, l, p;
    refRate = 32'd1000; gateMs = 16'd75; loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    chk("R5 busy after strobe", busy, 1);
    c = 0;
    while (busy) begin c++; @(negedge clk); end
    chk("R5 busy cycles", c, 115);
    measurePeriod(h, l, p);
    chk("R7 running period keeps old low", l, 60);
    checkPeriod("R3 new period 1000/75", 40, 35);
  endtask

  task automatic testRounding();
    longint rates[3] = '{1030, 1010, 1004};
    longint mss[3]   = '{55, 50, 100};
    for (int i = 0; i < 3; i++) begin
      doLoad(rates[i], mss[i]);
      waitIdle();
      waitStart();
      checkPeriod("R3 rounding", expHigh(rates[i]), expLow(rates[i], mss[i]));
    end
  endtask

  task automatic testIgnore();
    int c;
    refRate = 32'd1000; gateMs = 16'd75; loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    c = 0;
    while (busy) begin
      c++;
      loadStrobe = (c == 10);
      gateMs = (c == 10) ? 16'd90 : 16'd75;
      @(negedge clk);
    end
    loadStrobe = 1'b0;
    chk("R6 busy not restarted", c, 115);
    waitStart();
    checkPeriod("R6 second strobe ignored", 40, 35);
  endtask

  task automatic testClamp();
    doLoad(1000, 10);
    waitIdle();
    waitStart();
    checkPeriod("R4 clamp low", 40, expLow(1000, 10));
    doLoad(1000, 65000);
    waitIdle();
    waitStart();
    checkPeriod("R4 clamp high", 40, expLow(1000, 65000));
  endtask

  task automatic testCoincide();
    doLoad(1000, 200);
    waitIdle();
    waitStart();
    checkPeriod("R8 setup", 40, 160);
    repeat (84) @(negedge clk);
    refRate = 32'd1000; gateMs = 16'd75; loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    chk("R8 busy started", busy, 1);
    repeat (114) @(negedge clk);
    chk("R8 busy before edge", busy, 1);
    chk("R8 gate low before edge", gateOut, 0);
    @(negedge clk);
    chk("R8 busy falls at rise", busy, 0);
    chk("R8 rise on same edge", periodStart, 1);
    checkPeriod("R8 coincident period keeps old", 40, 160);
    checkPeriod("R8 following period new", 40, 35);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testDeferred();
    testRounding();
    testIgnore();
    testClamp();
    testCoincide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule